// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a binary up-counter whose state bits all change together on the rising clock edge. An active-low clear resets it to zero at once, with no clock needed. An active-low preset copies a parallel word into the count on the next edge. Two count enables decide whether the value advances. One enable gates only the stepping. The other, called the chain enable, gates both the stepping and the carry output.

The carry output goes high while the count holds its largest value and the chain enable is high. Wider counters are built by wiring each stage's carry to the next stage's chain enable. All stages share the clock, the clear, the preset and the local enable. The carry is combinational, so the whole chain settles inside one clock cycle and needs no extra gating.

Top module: `sync_counter`

## Requirements
- R1: A low level on `clearN` drives `countOut` to zero within the same clock phase, with no clock edge needed, whatever the other inputs are.
- R2: A rising edge with `loadN` low and `clearN` high copies `dataIn` into `countOut`, whatever the levels of both enables.
- R3: A rising edge with `loadN` high, `cntEnable` high and `chainEnable` high adds one to `countOut`.
- R4: A rising edge with `loadN` high and either enable low leaves `countOut` unchanged.
- R5: A counting edge from the all-ones value gives zero, and `carryOut` falls with that edge.
- R6: `carryOut` is 1 exactly when `countOut` is all ones and `chainEnable` is 1. `cntEnable` has no effect on it.
- R7: Changes on `loadN`, `cntEnable` or `chainEnable` between clock edges never change `countOut`.
- R8: Three 4-bit stages form a 12-bit synchronous counter when each stage's `carryOut` drives the next stage's `chainEnable`. In that chain, `dataIn` of stage k carries bits 4k+3..4k of the wide word.
- R9: While `clearN` is low, the count stays zero even with `loadN` low at a clock edge. Clear overrides preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous preset, active low |
| dataIn | input | WIDTH | Preset value |
| cntEnable | input | 1 | Local count enable, gates stepping only |
| chainEnable | input | 1 | Chain enable, gates stepping and carry |
| countOut | output | WIDTH | Current count |
| carryOut | output | 1 | High at all-ones while chainEnable is high |

## Verification
The hardest case to reach from the ports is a carry that crosses two stage boundaries of the 12-bit chain in a single edge. The chain must sit at 0x0FF or 0xFFF at the moment both enables are high. Random counting almost never lands there, so the stimulus presets the chain to values just below those boundaries and then counts through them. Clear pulses are also started between edges and held across an edge while preset is low. This tests the asynchronous response and the clear-over-preset priority together.

// File: rtl/sync_counter_pkg.sv
package sync_counter_pkg;
  typedef struct packed {
    logic doLoad;
    logic doCount;
  } ctrStrobes_t;
endpackage

// File: rtl/ctr_control.sv
module ctr_control
  import sync_counter_pkg::*;
(
  input  logic        clk,
  input  logic        clearN,
  input  logic        loadN,
  input  logic        cntEnable,
  input  logic        chainEnable,
  output ctrStrobes_t strobes
);
  // preset outranks stepping; stepping needs both enables
  always_comb begin
    strobes.doLoad  = ~loadN;
    strobes.doCount = loadN & cntEnable & chainEnable;
  end

  AST_STEP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!clearN)
    strobes.doCount |-> (cntEnable && chainEnable)); // R3
  AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk) disable iff (!clearN)
    !loadN |-> !strobes.doCount); // R2
endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import sync_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  ctrStrobes_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             chainEnable,
  output logic [WIDTH-1:0] countQ,
  output logic             carryOut
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] toggleMask;
  logic [WIDTH-1:0] nextCount;
  logic             atTop;

  // look-ahead: bit i toggles when every lower bit is one
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_look
      if (i == 0) begin : g_lsb
        assign toggleMask[i] = 1'b1;
      end else begin : g_upper
        assign toggleMask[i] = &countQ[i-1:0];
      end
    end
  endgenerate

  assign atTop = toggleMask[WIDTH-1] & countQ[WIDTH-1];

  always_comb begin
    if (strobes.doLoad)       nextCount = dataIn;
    else if (strobes.doCount) nextCount = countQ ^ toggleMask;
    else                      nextCount = countQ;
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) countQ <= '0;
    else         countQ <= nextCount;
  end

  assign carryOut = atTop & chainEnable;

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clearN |-> (countQ == '0)); // R1
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clearN)
    strobes.doLoad |=> (countQ == $past(dataIn))); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!clearN)
    (strobes.doCount && countQ != ALL_ONES) |=> (countQ == $past(countQ) + 1'b1)); // R3
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!clearN)
    (!strobes.doLoad && !strobes.doCount) |=> $stable(countQ)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clearN)
    (strobes.doCount && countQ == ALL_ONES) |=> (countQ == '0 && !carryOut)); // R5
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clearN)
    carryOut |-> (chainEnable && countQ == ALL_ONES)); // R6
endmodule

// File: rtl/sync_counter.sv
module sync_counter
  import sync_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             cntEnable,
  input  logic             chainEnable,
  output logic [WIDTH-1:0] countOut,
  output logic             carryOut
);
  ctrStrobes_t strobes;

  ctr_control u_control (
    .clk         (clk),
    .clearN      (clearN),
    .loadN       (loadN),
    .cntEnable   (cntEnable),
    .chainEnable (chainEnable),
    .strobes     (strobes)
  );

  ctr_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk         (clk),
    .clearN      (clearN),
    .strobes     (strobes),
    .dataIn      (dataIn),
    .chainEnable (chainEnable),
    .countQ      (countOut),
    .carryOut    (carryOut)
  );
endmodule

// File: tb/sim_sync_counter.sv
module sim_sync_counter;
  logic        clk = 1'b0;
  logic        clearN = 1'b0;
  logic        loadN = 1'b1;
  logic        cntEnable = 1'b0;
  logic        chainIn = 1'b0;
  logic [11:0] dataBus = '0;
  logic [3:0]  cnt0;
  logic        carry0;
  logic [11:0] chainCount;
  logic [2:0]  stageCarry;
  logic [2:0]  stageEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0]  refSingle = '0;
  logic [11:0] refChain = '0;

  typedef struct {
    logic [3:0]  c;
    logic        cy;
    logic [11:0] w;
    logic        wcy;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  sync_counter #(.WIDTH(4)) u0 (
    .clk(clk), .clearN(clearN), .loadN(loadN), .dataIn(dataBus[3:0]),
    .cntEnable(cntEnable), .chainEnable(chainIn), .countOut(cnt0), .carryOut(carry0)
  );

  // R8: three-stage cascade
  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign stageEn[g] = chainIn;
      end else begin : g_next
        assign stageEn[g] = stageCarry[g-1];
      end
      sync_counter #(.WIDTH(4)) uStage (
        .clk(clk), .clearN(clearN), .loadN(loadN), .dataIn(dataBus[4*g +: 4]),
        .cntEnable(cntEnable), .chainEnable(stageEn[g]),
        .countOut(chainCount[4*g +: 4]), .carryOut(stageCarry[g])
      );
    end
  endgenerate

  task automatic checkVal(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  task automatic pushExp(input string tag);
    expItem_t it;
    it.c = refSingle;
    it.cy = (refSingle == 4'hF) && chainIn;
    it.w = refChain;
    it.wcy = (refChain == 12'hFFF) && chainIn;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // driver: one clock edge per call
  task automatic applyStep(input logic l, input logic [11:0] d, input logic e,
                           input logic ch, input string tag);
    @(negedge clk);
    loadN = l; dataBus = d; cntEnable = e; chainIn = ch;
    @(posedge clk);
    if (!l) begin
      refSingle = d[3:0];
      refChain = d;
    end else if (e && ch) begin
      refSingle = refSingle + 4'd1;
      refChain = refChain + 12'd1;
    end
    pushExp(tag);
  endtask

  // clear started mid-cycle, held across one edge
  task automatic clearPulse(input logic ldDuring, input string tag);
    @(negedge clk);
    loadN = ldDuring; dataBus = 12'h9A5; cntEnable = 1'b1; chainIn = 1'b1;
    #3 clearN = 1'b0;
    #1;
    checkVal("R1 async single", int'(cnt0), 0);
    checkVal("R1 async chain", int'(chainCount), 0);
    @(posedge clk);
    refSingle = '0;
    refChain = '0;
    pushExp(tag);
    @(negedge clk);
    clearN = 1'b1; loadN = 1'b1; cntEnable = 1'b0;
  endtask

  // control glitches between edges
  task automatic glitchStep();
    @(negedge clk);
    loadN = 1'b0; dataBus = 12'hABC; cntEnable = 1'b1; chainIn = 1'b1;
    #2;
    checkVal("R7 single", int'(cnt0), int'(refSingle));
    checkVal("R7 chain", int'(chainCount), int'(refChain));
    loadN = 1'b1; cntEnable = 1'b0; chainIn = 1'b0;
    #2;
    checkVal("R7 single after", int'(cnt0), int'(refSingle));
    chainIn = 1'b1;
    @(posedge clk);
    pushExp("R7 hold");
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checkVal({it.tag, " count"}, int'(cnt0), int'(it.c));
        checkVal({it.tag, " carry"}, int'(carry0), int'(it.cy));
        checkVal({it.tag, " R8 chain"}, int'(chainCount), int'(it.w));
        checkVal({it.tag, " R8 chain carry"}, int'(stageCarry[2]), int'(it.wcy));
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    #25;
    checkVal("R1 reset count", int'(cnt0), 0);
    checkVal("R1 reset carry", int'(carry0), 0);
    checkVal("R1 reset chain", int'(chainCount), 0);
    @(negedge clk);
    clearN = 1'b1;

    applyStep(1'b0, 12'h00E, 1'b0, 1'b0, "R2 load no enables");
    applyStep(1'b1, 12'h000, 1'b1, 1'b1, "R3 count");
    applyStep(1'b1, 12'h000, 1'b1, 1'b0, "R4 chain low hold");
    applyStep(1'b1, 12'h000, 1'b0, 1'b1, "R6 local low carry");
    applyStep(1'b1, 12'h000, 1'b1, 1'b1, "R5 wrap");
    applyStep(1'b0, 12'h3F7, 1'b1, 1'b1, "R2 load over enables");
    applyStep(1'b1, 12'h000, 1'b0, 1'b0, "R4 both low hold");
    glitchStep();
    clearPulse(1'b0, "R9 clear over load");
    clearPulse(1'b1, "R1 clear held");

    applyStep(1'b0, 12'h0FE, 1'b0, 1'b0, "R8 preset 0FE");
    for (int k = 0; k < 3; k++) applyStep(1'b1, 12'h000, 1'b1, 1'b1, "R8 cross");
    applyStep(1'b0, 12'hFFD, 1'b0, 1'b1, "R8 preset FFD");
    for (int k = 0; k < 4; k++) applyStep(1'b1, 12'h000, 1'b1, 1'b1, "R8 rollover");

    for (int n = 0; n < 600; n++) begin
      int pick;
      pick = int'($urandom_range(0, 39));
      if (pick == 0) clearPulse(1'($urandom_range(0, 1)), "R9 random clear");
      else if (pick == 1) glitchStep();
      else applyStep((pick > 4), 12'($urandom()), 1'($urandom_range(0, 3) != 0),
                     1'($urandom_range(0, 5) != 0), "R3 random");
    end

    repeat (3) @(posedge clk);
    #6;
    finishRun();
  end
endmodule